// File: doc/BRIEF.md
# Circular Delay-Line Address Generator

This block produces the 5-bit address of a small data memory. The memory holds three histories for a pulse-analysis datapath: a ring of recent input samples, a longer ring of second-derivative values and a single slot for the output feature. Each history ring keeps a pointer to its newest entry. One `step` pulse per new sample moves every ring forward by one slot. The slot that becomes current is the one that held the oldest entry, so the newest value is written over the oldest in place.

The datapath chooses a history with a 3-bit region code and asks for an older entry by giving an age on `delay`. The address is formed without a clock from the registered pointers and these two inputs, and it always stays inside the chosen region. A `wipe` pulse returns every ring to its first slot.

Top module: `region_addr_gen`

## Requirements
- R1: After reset every ring points at its first slot. With `delay` = 0, code 3'b011 gives address 1, code 3'b001 gives address 6 and code 3'b010 gives address 22.
- R2: Each cycle with `step` high and `wipe` low moves the input-history slot by one at the next rising edge. From slot 1 the addresses with `delay` = 0 run 1, 2, 3, 4, 5 and then 1 again.
- R3: Code 3'b011 selects the five-slot input history at addresses 1 to 5. With current slot p and age d, the address is ((p-1-(d mod 5)) mod 5)+1. For example, slot 2 with age 1 gives address 1 and slot 1 with age 1 gives address 5. The address follows `sel` and `delay` in the same cycle.
- R4: Code 3'b001 selects the sixteen-slot second-derivative history at addresses 6 to 21. Its address is 5+((q-1-(d mod 16)) mod 16)+1, where q is the slot. The same `step` moves q, and q wraps from 16 to 1.
- R5: Code 3'b010 always gives address 22, whatever the values of `delay`, `step` and the pointers.
- R6: A cycle with `wipe` high returns every ring to slot 1 at the next rising edge, even when `step` is high in the same cycle.
- R7: The codes 3'b000, 3'b100, 3'b101, 3'b110 and 3'b111 give address 31.
- R8: A cycle with `step` and `wipe` both low leaves every pointer unchanged.
- R9: After a step, the input-history address with `delay` = 0 equals the address that `delay` = 4 gave in the cycle of that step. The oldest slot is therefore reused for the newest sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; pointers change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | Advance every history ring by one slot |
| wipe | input | 1 | Return every ring to slot 1; takes priority over step |
| sel | input | 3 | Region code: 011 input, 001 derivative, 010 feature |
| delay | input | 4 | Age of the requested entry, 0 for the newest |
| addr | output | 5 | Memory address of the requested entry |

## Verification
`step` and `wipe` can both be high in one cycle, and the bench drives that case on purpose while the pointers are away from slot 1. The result is judged in the next cycle: with `delay` = 0 the bench expects the first-slot address of both the input and the derivative history, and not the advanced address. A pseudo-random phase also raises `wipe` now and then on top of random steps. A behavioural model that treats clear as the stronger command follows these collisions cycle by cycle.

// File: rtl/addr_gen_pkg.sv
`timescale 1ns/1ps
package addr_gen_pkg;

    // Region codes decoded from the select input.
    typedef enum logic [2:0] {
        RGN_NONE  = 3'b000,
        RGN_DERIV = 3'b001,
        RGN_FEAT  = 3'b010,
        RGN_INPUT = 3'b011
    } region_e;

    // Number of addressable history regions.
    localparam int NREG = 3;

endpackage

// File: rtl/ring_slot_ptr.sv
`timescale 1ns/1ps
// Newest-entry pointer of one history ring, counting slots 1..LEN.
module ring_slot_ptr #(
    parameter int LEN = 5,
    parameter int SW  = $clog2(LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          wipe,
    output logic [SW-1:0] slot
);

    typedef struct packed {
        logic [SW-1:0] slot;
    } ring_st_t;

    localparam logic [SW-1:0] FIRST = SW'(1);
    localparam logic [SW-1:0] LAST  = SW'(LEN);

    ring_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wipe) begin
            st_d.slot = FIRST;
        end else if (step) begin
            st_d.slot = (st_q.slot == LAST) ? FIRST : st_q.slot + FIRST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{slot: FIRST};
        end else begin
            st_q <= st_d;
        end
    end

    assign slot = st_q.slot;

endmodule

// File: rtl/ring_tap.sv
`timescale 1ns/1ps
// Maps a ring slot and an age to an absolute address inside the region.
module ring_tap #(
    parameter int LEN  = 5,
    parameter int BASE = 0,
    parameter int SW   = 5,
    parameter int DW   = 4,
    parameter int AW   = 5
) (
    input  logic [SW-1:0] slot,
    input  logic [DW-1:0] delay,
    output logic [AW-1:0] addr
);

    int off_c;
    int age_c;
    int pos_c;

    always_comb begin
        off_c = int'(slot) - 1;
        age_c = int'(delay) % LEN;
        pos_c = (off_c >= age_c) ? (off_c - age_c) : (off_c + LEN - age_c);
        addr  = AW'(BASE + pos_c + 1);
    end

endmodule

// File: rtl/region_addr_gen.sv
`timescale 1ns/1ps
module region_addr_gen
    import addr_gen_pkg::*;
#(
    parameter int AW     = 5,
    parameter int DW     = 4,
    parameter int X_LEN  = 5,
    parameter int X_BASE = 0,
    parameter int D_LEN  = 16,
    parameter int D_BASE = 5,
    parameter int F_LEN  = 1,
    parameter int F_BASE = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          wipe,
    input  logic [2:0]    sel,
    input  logic [DW-1:0] delay,
    output logic [AW-1:0] addr
);

    localparam int         LEN_A  [NREG] = '{X_LEN, D_LEN, F_LEN};
    localparam int         BASE_A [NREG] = '{X_BASE, D_BASE, F_BASE};
    localparam logic [2:0] CODE_A [NREG] = '{RGN_INPUT, RGN_DERIV, RGN_FEAT};
    localparam logic [AW-1:0] MISS = '1;

    logic [AW-1:0] slot_w [NREG];
    logic [AW-1:0] tap_w  [NREG];

    generate
        for (genvar gi = 0; gi < NREG; gi++) begin : g_rgn
            ring_slot_ptr #(
                .LEN (LEN_A[gi]),
                .SW  (AW)
            ) u_ptr (
                .clk   (clk),
                .rst_n (rst_n),
                .step  (step),
                .wipe  (wipe),
                .slot  (slot_w[gi])
            );

            ring_tap #(
                .LEN  (LEN_A[gi]),
                .BASE (BASE_A[gi]),
                .SW   (AW),
                .DW   (DW),
                .AW   (AW)
            ) u_tap (
                .slot  (slot_w[gi]),
                .delay (delay),
                .addr  (tap_w[gi])
            );
        end
    endgenerate

    always_comb begin
        addr = MISS;
        for (int i = 0; i < NREG; i++) begin
            if (sel == CODE_A[i]) begin
                addr = tap_w[i];
            end
        end
    end

endmodule

// File: rtl/addr_gen_chk.sv
`timescale 1ns/1ps
module addr_gen_chk
    import addr_gen_pkg::*;
#(
    parameter int AW     = 5,
    parameter int DW     = 4,
    parameter int X_LEN  = 5,
    parameter int X_BASE = 0,
    parameter int D_LEN  = 16,
    parameter int D_BASE = 5,
    parameter int F_BASE = 21
) (
    input logic          clk,
    input logic          rst_n,
    input logic          step,
    input logic          wipe,
    input logic [2:0]    sel,
    input logic [DW-1:0] delay,
    input logic [AW-1:0] addr
);

    logic known_code;
    assign known_code = (sel == RGN_INPUT) || (sel == RGN_DERIV) || (sel == RGN_FEAT);

    assert_input_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == RGN_INPUT) |-> (int'(addr) > X_BASE && int'(addr) <= X_BASE + X_LEN));

    assert_deriv_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == RGN_DERIV) |-> (int'(addr) > D_BASE && int'(addr) <= D_BASE + D_LEN));

    assert_feature_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == RGN_FEAT) |-> (int'(addr) == F_BASE + 1));

    assert_unknown_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !known_code |-> (addr == '1));

    assert_clear_home_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wipe) && sel == RGN_INPUT && delay == '0) |-> (int'(addr) == X_BASE + 1));

    assert_clear_home_deriv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wipe) && sel == RGN_DERIV && delay == '0) |-> (int'(addr) == D_BASE + 1));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel) == RGN_INPUT && $past(delay) == '0 && !$past(step) && !$past(wipe)
         && sel == RGN_INPUT && delay == '0) |-> (addr == $past(addr)));

    assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel) == RGN_INPUT && $past(delay) == '0 && $past(step) && !$past(wipe)
         && sel == RGN_INPUT && delay == '0)
        |-> (int'(addr) == ((int'($past(addr)) == X_BASE + X_LEN) ? X_BASE + 1
                                                                 : int'($past(addr)) + 1)));

    assert_oldest_reuse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel) == RGN_INPUT && int'($past(delay)) == X_LEN - 1 && $past(step) && !$past(wipe)
         && sel == RGN_INPUT && delay == '0) |-> (addr == $past(addr)));

endmodule

bind region_addr_gen addr_gen_chk #(
    .AW     (AW),
    .DW     (DW),
    .X_LEN  (X_LEN),
    .X_BASE (X_BASE),
    .D_LEN  (D_LEN),
    .D_BASE (D_BASE),
    .F_BASE (F_BASE)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .wipe  (wipe),
    .sel   (sel),
    .delay (delay),
    .addr  (addr)
);

// File: tb/sim_region_addr_gen.sv
`timescale 1ns/1ps
module sim_region_addr_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step = 1'b0;
    logic       wipe = 1'b0;
    logic [2:0] sel = 3'b000;
    logic [3:0] delay = 4'd0;
    logic [4:0] addr;

    int errs  = 0;
    int total = 0;
    int px = 1;      // model: input-history slot 1..5
    int pd = 1;      // model: derivative-history slot 1..16
    int seen = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    region_addr_gen u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .wipe  (wipe),
        .sel   (sel),
        .delay (delay),
        .addr  (addr)
    );

    function automatic int expect_addr(input int code, input int d);
        case (code)
            3: return ((px - 1 - (d % 5) + 5) % 5) + 1;
            1: return 5 + ((pd - 1 - (d % 16) + 16) % 16) + 1;
            2: return 22;
            default: return 31;
        endcase
    endfunction

    task automatic chk(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare, then advance the model.
    task automatic tick(input bit s, input bit w, input int code, input int d, input string tag);
        @(negedge clk);
        step  = s;
        wipe  = w;
        sel   = code[2:0];
        delay = d[3:0];
        #2;
        seen = int'(addr);
        chk(seen, expect_addr(code, d), tag);
        @(posedge clk);
        #1;
        if (w) begin
            px = 1;
            pd = 1;
        end else if (s) begin
            px = (px == 5) ? 1 : px + 1;
            pd = (pd == 16) ? 1 : pd + 1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++;
            total++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, total);
            $finish;
        end
    end

    initial begin
        int saved;
        int lfsr;
        int code;
        string tg;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: first slots after reset
        tick(0, 0, 3, 0, "R1");
        chk(seen, 1, "R1");
        tick(0, 0, 1, 0, "R1");
        chk(seen, 6, "R1");
        tick(0, 0, 2, 0, "R1");
        chk(seen, 22, "R1");

        // R2: walk the input ring through one wrap
        for (int k = 0; k < 6; k++) tick(1, 0, 3, 0, "R2");
        tick(0, 0, 3, 0, "R2");
        chk(seen, 2, "R2");

        // R3: every age at slot 2 (age 1 -> address 1), then wrap at slot 1
        for (int d = 0; d < 16; d++) tick(0, 0, 3, d, "R3");
        tick(0, 0, 3, 1, "R3");
        chk(seen, 1, "R3");
        for (int k = 0; k < 4; k++) tick(1, 0, 3, 2, "R3");
        tick(0, 0, 3, 1, "R3");
        chk(seen, 5, "R3");

        // R4: derivative ring through more than one wrap, all ages
        for (int k = 0; k < 17; k++) tick(1, 0, 1, 3, "R4");
        for (int d = 0; d < 16; d++) tick(0, 0, 1, d, "R4");

        // R5: feature slot fixed under steps and ages
        for (int d = 0; d < 6; d++) tick(1, 0, 2, d * 3, "R5");

        // R6: clear alone, then clear together with step
        tick(1, 0, 3, 0, "R6");
        tick(0, 1, 3, 0, "R6");
        tick(0, 0, 3, 0, "R6");
        chk(seen, 1, "R6");
        tick(1, 0, 1, 0, "R6");
        tick(1, 0, 1, 0, "R6");
        tick(1, 1, 1, 0, "R6");
        tick(0, 0, 1, 0, "R6");
        chk(seen, 6, "R6");
        tick(0, 0, 3, 0, "R6");
        chk(seen, 1, "R6");

        // R7: unused codes, with pointers moving
        tick(1, 0, 0, 2, "R7");
        for (int c = 4; c < 8; c++) tick(1, 0, c, c, "R7");

        // R8: idle cycles hold every pointer
        tick(0, 0, 3, 0, "R8");
        saved = seen;
        tick(0, 0, 1, 2, "R8");
        tick(0, 0, 3, 0, "R8");
        chk(seen, saved, "R8");

        // R9: oldest slot becomes newest after a step
        for (int k = 0; k < 5; k++) begin
            tick(1, 0, 3, 4, "R9");
            saved = seen;
            tick(0, 0, 3, 0, "R9");
            chk(seen, saved, "R9");
        end

        // Mixed pseudo-random traffic against the model
        lfsr = 32'h1ace_0b57;
        for (int k = 0; k < 400; k++) begin
            lfsr = lfsr * 1103515245 + 12345;
            code = (lfsr >>> 8) & 7;
            case (code)
                3: tg = "R3";
                1: tg = "R4";
                2: tg = "R5";
                default: tg = "R7";
            endcase
            tick(((lfsr >>> 12) & 1) == 1, ((lfsr >>> 16) & 15) == 0, code,
                 (lfsr >>> 20) & 15, tg);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, total);
        $finish;
    end

endmodule